// File: doc/BRIEF.md
# Programmable Input Glitch Filter

This block qualifies a set of already-synchronized input lines before their levels reach a data read path or an edge/level interrupt detector. Each line has its own 4-bit count and 4-bit prescale select. A line's filtered output moves to a new level only after the raw input has held that level for count × 2^select consecutive clocks. With one small configuration field, the stability window therefore spans from a single clock up to 15 × 2^15 clocks. At a 2.5 ns clock that is about 1.2 ms.

A count of zero turns the filter off for that line, and the output then follows the input one register stage later. The window starts again when the input falls back to the filtered level, and also when software rewrites the count or the select. A line that has never been configured is expected to be given select 4 and count 9 by the surrounding configuration logic. That gives a 144-clock window, or 360 ns at 2.5 ns. The package carries these values, but the register decoding itself lives outside this block.

Top module: `input_qualifier`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, every filtered output is 0, whatever the raw inputs are.
- R2: A line whose count is 0 is in bypass: its filtered output equals the raw level sampled at the previous rising clock edge.
- R3: With a non-zero count, a filtered output only ever changes to the level the raw input held during the clocks that were counted. It never changes on a clock that does not complete a window.
- R4: With count C in 1..15 and select S in 0..15, the filtered output takes a new level at the C×2^S-th consecutive rising edge at which the raw input differs from the filtered output and the configuration is unchanged.
- R5: A raw input that returns to the current filtered level for even one sampled clock discards the partially counted window, and the next differing level needs a full window again.
- R6: A rising edge at which a line's count or select differs from its value at the previous edge restarts that line's window. That edge does not count toward the window.
- R7: The whole select range is usable: select 15 with count 1 needs exactly 32768 differing clocks, and select 4 with count 9 (the unconfigured default) needs exactly 144.
- R8: Lines are independent: one line's input, count and select never affect another line's output. Line n uses bits n of the level vectors and bits 4n+3..4n of the count and select vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| raw_i | input | LANES | Synchronized raw input level, one bit per line |
| cnt_i | input | LANES*CNT_W | Per-line window count; 0 selects bypass |
| sel_i | input | LANES*SEL_W | Per-line prescale select; one tick every 2^select clocks |
| filt_o | output | LANES | Filtered level, one bit per line |

## Verification
The bench probes the exact window edge: for 3×2^2, 9×2^4 and 1×2^15 it checks one clock before the flip and again at the flip. A design that is off by one prescale tick, or that starts its prescaler free-running out of phase, misses one of these two samples. Separate directed cases target the two restart rules. A glitch back to the filtered level just before the window ends must not let the old count carry over. A configuration rewrite in mid-window must not let the design finish early on stale counters. A bypass toggle on one line, while a neighbour is mid-window, exposes crossed lane slices. A long random phase then changes count, select and levels freely and compares every line on every clock against a bench model that counts consecutive differing clocks directly.

// File: rtl/iq_pkg.sv
`timescale 1ns/1ps
package iq_pkg;
  // Field widths of the per-line filter setting
  localparam int FILT_CNT_W = 4;
  localparam int FILT_SEL_W = 4;
  // Setting expected for a line that was never configured
  localparam int FILT_DFLT_CNT = 9;
  localparam int FILT_DFLT_SEL = 4;
endpackage

// File: rtl/iq_prescale.sv
`timescale 1ns/1ps
// Per-line prescaler: emits one tick every 2^sel clocks while not cleared.
module iq_prescale #(
  parameter int SEL_W = 4,
  localparam int PRE_W = (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PRE_W:0]   span;
  logic [PRE_W-1:0] limit;
  logic             pre_en;

  always_comb begin
    span   = ((PRE_W+1)'(1) << sel_i) - (PRE_W+1)'(1);
    limit  = span[PRE_W-1:0];
    tick_o = !clr_i && (pre_q == limit);
    pre_en = !(clr_i && (pre_q == '0));
    if (clr_i || tick_o) pre_d = '0;
    else                 pre_d = pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (pre_en) pre_q <= pre_d;
  end

  // R7: with a select above 0, two ticks are never adjacent
  p_tick_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && sel_i != '0) |=> !tick_o);

endmodule

// File: rtl/iq_window.sv
`timescale 1ns/1ps
// Per-line window counter and filtered level register.
module iq_window #(
  parameter int CNT_W = 4,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             tick_i,
  output logic             clr_o,
  output logic             filt_o
);

  logic [CNT_W+SEL_W-1:0] cfg_q;
  logic [CNT_W-1:0]       run_q, run_d;
  logic [CNT_W:0]         run_inc;
  logic                   filt_q, filt_d;
  logic                   bypass, cfg_chg, same;

  always_comb begin
    bypass  = (cnt_i == '0);
    cfg_chg = ({cnt_i, sel_i} != cfg_q);
    same    = (raw_i == filt_q);
    clr_o   = bypass || cfg_chg || same;
    run_inc = {1'b0, run_q} + (CNT_W+1)'(1);
    filt_d  = filt_q;
    run_d   = run_q;
    if (bypass) begin
      filt_d = raw_i;
      run_d  = '0;
    end else if (cfg_chg || same) begin
      run_d  = '0;
    end else if (tick_i) begin
      if (run_inc == {1'b0, cnt_i}) begin
        filt_d = raw_i;
        run_d  = '0;
      end else begin
        run_d  = run_inc[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      run_q  <= '0;
      filt_q <= 1'b0;
    end else begin
      cfg_q  <= {cnt_i, sel_i};
      run_q  <= run_d;
      filt_q <= filt_d;
    end
  end

  assign filt_o = filt_q;

  // R2: bypass passes the sampled level through one register
  p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_i == '0) |=> (filt_q == $past(raw_i)));
  // R3: no change without a completed prescale tick
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_i != '0 && !tick_i) |=> $stable(filt_q));
  // R3: a change lands on the level that was on the input
  p_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_i != '0 && tick_i) |=> (filt_q == $past(filt_q) || filt_q == $past(raw_i)));
  // R4: the tick count stays below the programmed count
  p_run_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_i != '0 && !cfg_chg) |-> (run_q < cnt_i));
  // R5: returning to the filtered level discards progress
  p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_i != '0 && raw_i == filt_q) |=> (run_q == '0));
  // R6: a configuration change discards progress
  p_cfg_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> (run_q == '0));

endmodule

// File: rtl/input_qualifier.sv
`timescale 1ns/1ps
// Multi-line programmable input glitch filter.
module input_qualifier #(
  parameter int LANES = 4,
  parameter int CNT_W = iq_pkg::FILT_CNT_W,
  parameter int SEL_W = iq_pkg::FILT_SEL_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LANES-1:0]       raw_i,
  input  logic [LANES*CNT_W-1:0] cnt_i,
  input  logic [LANES*SEL_W-1:0] sel_i,
  output logic [LANES-1:0]       filt_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic clr, tick;

    iq_prescale #(.SEL_W(SEL_W)) i_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clr),
      .sel_i  (sel_i[g*SEL_W +: SEL_W]),
      .tick_o (tick)
    );

    iq_window #(.CNT_W(CNT_W), .SEL_W(SEL_W)) i_win (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (raw_i[g]),
      .cnt_i  (cnt_i[g*CNT_W +: CNT_W]),
      .sel_i  (sel_i[g*SEL_W +: SEL_W]),
      .tick_i (tick),
      .clr_o  (clr),
      .filt_o (filt_o[g])
    );
  end

endmodule

// File: tb/test_input_qualifier.sv
`timescale 1ns/1ps
module test_input_qualifier;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 4;
  localparam int CW = 4;
  localparam int SW = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [LANES-1:0] raw;
  logic [LANES*CW-1:0] cnt;
  logic [LANES*SW-1:0] sel;
  logic [LANES-1:0] filt;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit sb_on = 1'b0;

  input_qualifier #(.LANES(LANES), .CNT_W(CW), .SEL_W(SW)) i_input_qualifier (
    .clk(clk), .rst_n(rst_n), .raw_i(raw), .cnt_i(cnt), .sel_i(sel), .filt_o(filt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference: count consecutive differing edges directly (R3, R4, R5, R6)
  int        m_run [LANES];
  logic      m_filt[LANES];
  logic [7:0] m_cfg [LANES];

  always @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (!rst_n) begin
        m_run[l] = 0; m_filt[l] = 1'b0; m_cfg[l] = 8'h00;
      end else begin
        if (cnt[l*CW +: CW] == 0) begin
          m_filt[l] = raw[l]; m_run[l] = 0;
        end else if ({cnt[l*CW +: CW], sel[l*SW +: SW]} != m_cfg[l]) begin
          m_run[l] = 0;
        end else if (raw[l] == m_filt[l]) begin
          m_run[l] = 0;
        end else begin
          m_run[l] = m_run[l] + 1;
          if (m_run[l] == (int'(cnt[l*CW +: CW]) << sel[l*SW +: SW])) begin
            m_filt[l] = raw[l]; m_run[l] = 0;
          end
        end
        m_cfg[l] = {cnt[l*CW +: CW], sel[l*SW +: SW]};
      end
    end
  end

  // Scoreboard covering R3 and R4 on every line, every clock
  always @(negedge clk) begin
    if (sb_on && rst_n) begin
      for (int l = 0; l < LANES; l++) begin
        checks++;
        if (filt[l] !== m_filt[l]) begin
          failures++;
          $display("FAIL R4 scoreboard lane %0d got %b expected %b", l, filt[l], m_filt[l]);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog expired got cycle %0d expected fewer", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [LANES-1:0] got, input logic [LANES-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got %b expected %b", req, got, exp);
    end
  endtask

  task automatic set_cfg(input int l, input int c, input int s);
    cnt[l*CW +: CW] = CW'(c);
    sel[l*SW +: SW] = SW'(s);
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    raw = '1;
    cnt = '0;
    sel = '0;
    step(3);
    chk("R1 in reset", filt, 4'b0000);
    rst_n = 1'b1;
    sb_on = 1'b1;
    chk("R1 at release", filt, 4'b0000);
    step(1);
    chk("R2 bypass follows", filt, 4'b1111);
    raw[2] = 1'b0;
    step(1);
    chk("R2 bypass single clock", filt, 4'b1011);

    // R4: count 3, select 2 -> 12 clocks
    set_cfg(0, 3, 2);
    step(2);
    raw[0] = 1'b0;
    step(11);
    chk("R4 one before window", filt & 4'b0001, 4'b0001);
    step(1);
    chk("R4 at window", filt & 4'b0001, 4'b0000);

    // R5: glitch back discards progress
    raw[0] = 1'b1;
    step(11);
    raw[0] = 1'b0;
    step(1);
    chk("R5 glitch absorbed", filt & 4'b0001, 4'b0000);
    raw[0] = 1'b1;
    step(11);
    chk("R5 full window needed again", filt & 4'b0001, 4'b0000);
    step(1);
    chk("R5 new level after full window", filt & 4'b0001, 4'b0001);

    // R6: configuration change mid-window restarts
    raw[0] = 1'b0;
    step(6);
    set_cfg(0, 3, 1);
    step(1);
    step(5);
    chk("R6 restart after rewrite", filt & 4'b0001, 4'b0001);
    step(1);
    chk("R6 window of new setting", filt & 4'b0001, 4'b0000);

    // R7: default setting 9 x 2^4 = 144
    set_cfg(0, 9, 4);
    step(1);
    raw[0] = 1'b1;
    step(143);
    chk("R7 default one before", filt & 4'b0001, 4'b0000);
    step(1);
    chk("R7 default at window", filt & 4'b0001, 4'b0001);

    // R7: top select 1 x 2^15 = 32768
    set_cfg(0, 1, 15);
    step(1);
    raw[0] = 1'b0;
    step(32767);
    chk("R7 top select one before", filt & 4'b0001, 4'b0001);
    step(1);
    chk("R7 top select at window", filt & 4'b0001, 4'b0000);

    // R8: lane 1 filtered while lane 0 bypasses
    set_cfg(0, 0, 0);
    set_cfg(1, 2, 1);
    step(2);
    raw[1] = 1'b0;
    raw[0] = 1'b1;
    step(3);
    chk("R8 lane1 still counting, lane0 bypass", filt & 4'b0011, 4'b0011);
    raw[0] = 1'b0;
    step(1);
    chk("R8 lane1 at window, lane0 bypass", filt & 4'b0011, 4'b0000);

    // Random phase: levels and settings change freely (R3, R4, R5, R6, R8)
    for (int i = 0; i < 20000; i++) begin
      for (int l = 0; l < LANES; l++) begin
        if (($urandom % 64) == 0) set_cfg(l, int'($urandom % 5), int'($urandom % 4));
        if (($urandom % 6) == 0) raw[l] = ~raw[l];
      end
      step(1);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule